// File: doc/BRIEF.md
# PCM Long-Frame Audio Serializer

This block turns parallel audio samples into a serial PCM stream that uses a long frame-sync pulse. A sample arrives through a valid/ready handshake and waits in a one-entry holding register. At the start of every frame it moves into a shadow register, so the next sample can be accepted while the current one is still being shifted out. Each frame sends one 16-bit sample, most significant bit first. When the wide channel is selected, 16 zero bits follow the data.

The serial clock is built from a tick input. Each tick is one half period of the serial clock, so a bit lasts two ticks. The first half of every bit sits at the selected idle level. The data and frame-sync lines change only on the edge back to the idle level, which keeps them steady across the sampling edge. Frame sync is high for the first 13 bits of each frame. While the run input is high, frames follow each other with no gap. When the run input falls, the block stops and the clock rests at its idle level.

If a frame starts and no sample is held, the frame carries zeros and a sticky underrun flag is raised. The flag stays set until it is cleared by a pulse on the clear input.

Top module: `pcm_lf_serializer`

## Requirements
- R1: While `run` is low, `sck_o` equals `clk_pol` and `sd_o`/`fs_o` are 0. While running, each bit spans two `bit_tick` pulses, and the first half of the bit is at the idle level.
- R2: `sd_o` and `fs_o` change only when `sck_o` returns to its idle level. They never change at the same moment `sck_o` leaves the idle level (the sampling edge).
- R3: `fs_o` is 1 during frame bits 0 to 12 (13 bit periods) and 0 for every later bit of the frame.
- R4: Frame bit k (k = 0..15) carries sample bit 15-k, so the MSB goes first.
- R5: With `chan_long` = 1 the frame is 32 bits, and bits 16..31 are 0. With `chan_long` = 0 the frame is 16 bits with no padding.
- R6: While `run` stays high, bit 0 of the next frame (with `fs_o` = 1) comes right after the last bit of the previous frame.
- R7: `s_ready` is 1 exactly when the holding register is empty. A sample is taken when `s_valid` and `s_ready` are both 1. The held sample moves to the shadow register at frame start, which lets the next sample be accepted during the frame.
- R8: A frame that starts with the holding register empty sends all-zero data and sets `underrun`. `underrun` stays 1 until `urun_clr` is pulsed. If a set and a clear land in the same cycle, the set wins.
- R9: After reset: `sd_o` = 0, `fs_o` = 0, `s_ready` = 1, `underrun` = 0.
- R10: With `clk_pol` = 1 the clock is inverted (idle high, sampling on the falling edge). The data and sync timing relative to the sampling edge is the same as with `clk_pol` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Half-period enable for the serial clock |
| run | input | 1 | Start/continue frames; low stops and idles |
| chan_long | input | 1 | 1: 32-bit channel, 0: 16-bit channel |
| clk_pol | input | 1 | Serial clock idle level |
| s_valid | input | 1 | Sample valid |
| s_data | input | SAMPLE_W | Sample word |
| s_ready | output | 1 | Holding register empty |
| urun_clr | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| sck_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |

## Verification
The bench records `sd_o` and `fs_o` on every sampling edge of `sck_o`. It flags any change that coincides with that edge, which a design that updated data on the wrong edge would produce. It streams several samples, including 0x8001 and 0x7FFE, in both channel lengths and both polarities. This exposes LSB-first shifting, padding that leaks data bits, a sync pulse of 12 or 14 bits, and a gap or repeated bit between frames. It also starts frames with no held sample, to confirm zero data and a flag that stays set until it is cleared, and it checks that a sample pushed mid-frame does not corrupt the frame in flight.

// File: rtl/pcm_lf_pkg.sv
package pcm_lf_pkg;

  // Number of bit periods in one frame for the chosen channel width.
  function automatic int unsigned frame_len(input int unsigned sw, input logic long_ch);
    return long_ch ? (2 * sw) : sw;
  endfunction

  // Frame-sync level for bit position idx.
  function automatic logic sync_level(input int unsigned idx, input int unsigned fs_len);
    return idx < fs_len;
  endfunction

  // Data level for bit position idx: MSB first, then zero padding.
  function automatic logic data_level(input logic [63:0] word, input int unsigned sw,
                                      input int unsigned idx);
    return (idx < sw) ? word[sw - 1 - idx] : 1'b0;
  endfunction

endpackage

// File: rtl/pcm_lf_bit_timer.sv
module pcm_lf_bit_timer
  import pcm_lf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             chan_long,
  output logic             active,
  output logic             half,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_load
);

  logic last_bit;

  assign last_bit   = (32'(bit_idx) == (frame_len(SAMPLE_W, chan_long) - 32'd1));
  assign frame_load = run && tick && (!active || (half && last_bit));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active  <= 1'b0;
      half    <= 1'b0;
      bit_idx <= '0;
    end else if (tick) begin
      if (frame_load) begin
        active  <= 1'b1;
        half    <= 1'b0;
        bit_idx <= '0;
      end else begin
        half <= ~half;
        if (half) bit_idx <= bit_idx + IDX_W'(1);
      end
    end
  end

  // R1: every tick inside a frame flips the half-bit phase
  p_half_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && run && !frame_load) |=> (half != $past(half)));

  // R5: the bit index never runs past the frame length
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (32'(bit_idx) < frame_len(SAMPLE_W, chan_long)));

endmodule

// File: rtl/pcm_lf_sample_buf.sv
module pcm_lf_sample_buf #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                frame_load,
  input  logic                urun_clr,
  output logic [SAMPLE_W-1:0] shadow,
  output logic                underrun,
  output logic                urun_evt
);

  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_q;
  logic                accept;

  assign s_ready  = !hold_full;
  assign accept   = s_valid && !hold_full;
  assign urun_evt = frame_load && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      shadow    <= '0;
      underrun  <= 1'b0;
    end else begin
      hold_full <= accept || (hold_full && !frame_load);
      if (accept) hold_q <= s_data;
      if (frame_load) shadow <= hold_full ? hold_q : '0;
      if (urun_evt) underrun <= 1'b1;
      else if (urun_clr) underrun <= 1'b0;
    end
  end

  // R7: a held sample is not overwritten before it is consumed
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !frame_load) |=> (hold_q == $past(hold_q)));

  // R8: flag stays set without a clear
  p_urun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !urun_clr) |=> underrun);

  // R8: flag rises only after an empty frame start
  p_urun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(urun_evt));

endmodule

// File: rtl/pcm_lf_line_drv.sv
module pcm_lf_line_drv
  import pcm_lf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned FS_LEN   = 13
) (
  input  logic                active,
  input  logic                half,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic [SAMPLE_W-1:0] shadow,
  input  logic                clk_pol,
  output logic                sck,
  output logic                sd,
  output logic                fs
);

  always_comb begin
    sck = active ? (half ^ clk_pol) : clk_pol;
    sd  = active && data_level(64'(shadow), SAMPLE_W, 32'(bit_idx));
    fs  = active && sync_level(32'(bit_idx), FS_LEN);
  end

endmodule

// File: rtl/pcm_lf_serializer.sv
module pcm_lf_serializer #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned FS_LEN   = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                run,
  input  logic                chan_long,
  input  logic                clk_pol,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                urun_clr,
  output logic                underrun,
  output logic                sck_o,
  output logic                sd_o,
  output logic                fs_o
);

  localparam int unsigned IDX_W = $clog2(2 * SAMPLE_W);

  logic                active;
  logic                half;
  logic [IDX_W-1:0]    bit_idx;
  logic                frame_load;
  logic                urun_evt;
  logic [SAMPLE_W-1:0] shadow;
  logic                act_edge;

  // tick that moves the clock away from idle: the sampling edge
  assign act_edge = bit_tick && run && active && !half;

  pcm_lf_bit_timer #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .run(run), .chan_long(chan_long),
    .active(active), .half(half), .bit_idx(bit_idx), .frame_load(frame_load)
  );

  pcm_lf_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .frame_load(frame_load), .urun_clr(urun_clr), .shadow(shadow),
    .underrun(underrun), .urun_evt(urun_evt)
  );

  pcm_lf_line_drv #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .FS_LEN(FS_LEN)) u_drv (
    .active(active), .half(half), .bit_idx(bit_idx), .shadow(shadow),
    .clk_pol(clk_pol), .sck(sck_o), .sd(sd_o), .fs(fs_o)
  );

  // R1: clock rests at its idle level when no frame is running
  p_idle_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck_o == clk_pol && !sd_o && !fs_o));

  // R2: lines hold across the sampling edge
  p_sd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> ($stable(sd_o) && $stable(fs_o)));

  // R3: sync drops exactly at the end of its pulse
  p_fs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $fell(fs_o)) |-> (32'(bit_idx) == FS_LEN));

  // R5: padding bits are zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && 32'(bit_idx) >= SAMPLE_W) |-> !sd_o);

endmodule

// File: tb/pcm_lf_serializer_tb.sv
`timescale 1ns/1ps
module pcm_lf_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        run = 1'b0;
  logic        chan_long = 1'b1;
  logic        clk_pol = 1'b0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready;
  logic        urun_clr = 1'b0;
  logic        underrun;
  logic        sck_o, sd_o, fs_o;

  int n_chk = 0;
  int n_fail = 0;

  logic rec_sd [0:511];
  logic rec_fs [0:511];
  int   rec_n = 0;
  int   stab_err = 0;
  bit   mon_on = 0;
  logic p_sck = 1'b0, p_sd = 1'b0, p_fs = 1'b0;
  logic [15:0] smp [0:7];

  pcm_lf_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run), .chan_long(chan_long),
    .clk_pol(clk_pol), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .urun_clr(urun_clr), .underrun(underrun), .sck_o(sck_o), .sd_o(sd_o), .fs_o(fs_o)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk); bit_tick <= 1'b1;
    @(posedge clk); bit_tick <= 1'b0;
  end

  // Record lines at each sampling edge and catch changes on that edge (R2)
  always @(negedge clk) begin
    if (mon_on && sck_o != p_sck && sck_o == ~clk_pol) begin
      if (sd_o != p_sd || fs_o != p_fs) stab_err++;
      if (rec_n < 512) begin
        rec_sd[rec_n] = sd_o;
        rec_fs[rec_n] = fs_o;
      end
      rec_n++;
    end
    p_sck = sck_o; p_sd = sd_o; p_fs = fs_o;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    s_valid = 1'b1; s_data = v;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sck_o == 1'b0, "R9 sck", 32'(sck_o), 0);
    chk(sd_o == 1'b0 && fs_o == 1'b0, "R9 sd/fs", {sd_o, fs_o}, 0);
    chk(s_ready == 1'b1, "R9 ready", 32'(s_ready), 1);
    chk(underrun == 1'b0, "R9 underrun", 32'(underrun), 0);
  endtask

  task automatic t_idle_pol();
    @(negedge clk); clk_pol = 1'b1;
    repeat (6) @(negedge clk);
    chk(sck_o == 1'b1, "R1 R10 idle high", 32'(sck_o), 1);
    clk_pol = 1'b0;
    repeat (6) @(negedge clk);
    chk(sck_o == 1'b0, "R1 idle low", 32'(sck_o), 0);
  endtask

  task automatic t_handshake();
    push(16'h5A5A);
    @(negedge clk);
    chk(s_ready == 1'b0, "R7 held ready low", 32'(s_ready), 0);
    repeat (8) @(negedge clk);
    chk(s_ready == 1'b0, "R7 still held while stopped", 32'(s_ready), 0);
  endtask

  // Streams nf samples (the first is already pushed) and checks each frame
  task automatic t_stream(input bit lng, input bit pol, input int nf);
    int flen = lng ? 32 : 16;
    @(negedge clk);
    chan_long = lng; clk_pol = pol;
    p_sck = pol;
    rec_n = 0; stab_err = 0; mon_on = 1;
    if (s_ready) push(smp[0]);
    fork
      begin
        for (int i = 1; i < nf; i++) push(smp[i]);
      end
      begin
        @(negedge clk); run = 1'b1;
        wait (rec_n >= nf * flen);
        run = 1'b0;
      end
    join
    mon_on = 0;
    for (int f = 0; f < nf; f++) begin
      logic [31:0] a_sd = '0, e_sd = '0, a_fs = '0, e_fs = '0;
      for (int k = 0; k < flen; k++) begin
        a_sd[k] = rec_sd[f * flen + k];
        a_fs[k] = rec_fs[f * flen + k];
        e_sd[k] = (k < 16) ? smp[f][15 - k] : 1'b0;
        e_fs[k] = (k < 13);
      end
      chk(a_sd[15:0] == e_sd[15:0], "R4 msb-first data", a_sd, e_sd);
      if (lng) chk(a_sd[31:16] == 16'h0, "R5 zero padding", a_sd, e_sd);
      chk(a_fs == e_fs, "R3 sync 13 bits", a_fs, e_fs);
      if (f > 0) chk(rec_fs[f * flen] == 1'b1, "R6 back-to-back frame start",
                     32'(rec_fs[f * flen]), 1);
    end
    chk(stab_err == 0, pol ? "R10 R2 stable at sampling edge" : "R2 stable at sampling edge",
        stab_err, 0);
    chk(underrun == 1'b0, "R8 no underrun when fed", 32'(underrun), 0);
    @(negedge clk);
    chk(sck_o == pol, "R1 idle after stop", 32'(sck_o), 32'(pol));
  endtask

  task automatic t_underrun();
    @(negedge clk);
    chan_long = 1'b0; clk_pol = 1'b0; p_sck = 1'b0;
    rec_n = 0; mon_on = 1; run = 1'b1;
    wait (rec_n >= 32);
    run = 1'b0; mon_on = 0;
    begin
      logic [31:0] a = '0;
      for (int k = 0; k < 32; k++) a[k] = rec_sd[k];
      chk(a == 32'h0, "R8 zero data on underrun", a, 0);
    end
    chk(rec_fs[16] == 1'b1, "R5 R6 16-bit frame length", 32'(rec_fs[16]), 1);
    chk(underrun == 1'b1, "R8 flag set", 32'(underrun), 1);
    repeat (20) @(negedge clk);
    chk(underrun == 1'b1, "R8 flag sticky", 32'(underrun), 1);
    urun_clr = 1'b1;
    @(negedge clk); urun_clr = 1'b0;
    chk(underrun == 1'b0, "R8 flag cleared", 32'(underrun), 0);
  endtask

  initial begin
    smp[0] = 16'hA5C3; smp[1] = 16'h8001; smp[2] = 16'h7FFE; smp[3] = 16'hFFFF;
    smp[4] = 16'h1234; smp[5] = 16'h0F0F; smp[6] = 16'hC001; smp[7] = 16'h6996;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_pol();
    t_handshake();
    smp[0] = 16'h5A5A;
    t_stream(1'b1, 1'b0, 3);
    smp[0] = 16'hA5C3;
    t_stream(1'b0, 1'b1, 4);
    t_stream(1'b1, 1'b1, 3);
    t_stream(1'b0, 1'b0, 5);
    t_underrun();
    summary();
    $finish;
  end

endmodule